// File: doc/BRIEF.md
# Multi-Cycle 16-Bit Step-Sequenced Processor

This block is a small 16-bit processor built around a three-bus datapath. It has a four-entry register file and a 64-word memory that holds both program and data. A hardwired controller uses a step counter to walk each instruction through its fetch, decode and execute steps. Four operations are supported: a copy, an add, a branch taken when the last result is greater than zero, and a stop. The source operand can come from a register, from memory addressed by a register, from an inline constant, or from memory at an inline address. The destination is either a register or a memory word at an inline address.

At reset the memory is loaded from a constant image, given as a parameter. The processor then runs from address zero until it executes a stop. Debug outputs expose the program counter, the instruction word, the status flags and every register. A debug address input reads any memory word without disturbing execution, so a harness can inspect results once the processor has halted.

Top module: `cpu16_core`

## Requirements
- R1: While reset is asserted, the PC, instruction word, registers and flags read zero, halted is 0, and the debug read port returns the reset image (word 0 of the default image is 16'h1868).
- R2: Fetch takes steps 0, 1 and 2. The PC increments on the first clock edge of an instruction, and the instruction word appears after the third edge. An instruction with a memory source operand and a register destination lasts six cycles. One with an immediate or register source and a register destination lasts four.
- R3: The instruction fields are op[15:13], source mode[12:11], source register[10:9], destination mode[8], destination register[7:6] and value[5:0]. Source mode 00 reads the register. Mode 01 reads memory at the register's low six bits. Mode 10 uses the value sign-extended to 16 bits. Mode 11 reads memory at the value.
- R4: Op 001 (add) writes source plus destination. It sets N to result bit 15, Z when the result is 0, C to the carry out of bit 15, and V on two's-complement overflow.
- R5: Op 000 (copy) writes the source. It sets N and Z from the copied value and clears V and C.
- R6: Destination mode 1 writes the result to the memory word addressed by the value field. An add then uses that memory word as its second operand.
- R7: Op 110 adds the sign-extended value to the already incremented PC, but only when N=0 and Z=0. Otherwise the PC is left unchanged. Flags are never altered by this op.
- R8: Op 111 asserts halted. From then on the PC, instruction word, flags and registers stay frozen, and no fetch takes place.
- R9: dbg_data returns, in the same cycle, the memory word at dbg_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; reloads the memory image |
| halted | output | 1 | High once the stop op has executed |
| dbg_pc | output | 6 | Program counter |
| dbg_ir | output | 16 | Instruction register |
| dbg_flags | output | 4 | Status flags {N,Z,V,C} |
| dbg_regs | output | 64 | Register file, register k at bits [16k+15:16k] |
| dbg_addr | input | 6 | Debug memory read address |
| dbg_data | output | 16 | Memory word at dbg_addr |

## Verification
Each result has a known cycle in which it becomes visible. The PC moves on the first edge of an instruction, and the instruction word lands on the third. A register destination is written on the last step, which is the fourth edge for register or immediate sources and the sixth for memory sources. A memory destination is written two edges after that. The bench counts these edges from the release of reset and samples on falling edges. Later in the program it synchronises on the PC value that marks the fetch of a given instruction. At that point the previous instruction has completed, so its flags and register writes are checked before anything else can change them.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

   localparam int WORD_W = 16;
   localparam int VAL_W  = 6;
   localparam int RSEL_W = 2;
   localparam int STEP_W = 3;

   localparam logic [2:0] OP_COPY = 3'b000;
   localparam logic [2:0] OP_ADD  = 3'b001;
   localparam logic [2:0] OP_BPOS = 3'b110;
   localparam logic [2:0] OP_STOP = 3'b111;

   typedef struct packed {
      logic [2:0]        op;
      logic [1:0]        smode;
      logic [RSEL_W-1:0] sreg;
      logic              dmode;
      logic [RSEL_W-1:0] dreg;
      logic [VAL_W-1:0]  val;
   } instr_t;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } flags_t;

   typedef enum logic {ALU_PASS, ALU_ADD} alu_op_e;

   typedef enum logic [1:0] {MAR_HOLD, MAR_PC, MAR_REG, MAR_VAL} mar_sel_e;

   typedef struct packed {
      mar_sel_e mar_sel;
      logic     pc_inc;
      logic     pc_br;
      logic     mdr_ld;
      logic     ir_ld;
      logic     tmp_ld;
      logic     use_tmp;
      logic     reg_we;
      logic     mem_we;
      logic     flag_we;
      logic     step_clr;
      logic     stop_set;
      alu_op_e  alu_op;
   } ctl_t;

   // Default image: sums five words, then exercises flags, branches and a
   // memory destination before stopping.
   function automatic logic [64*WORD_W-1:0] demo_image();
      logic [WORD_W-1:0]   w [64];
      logic [64*WORD_W-1:0] img;
      for (int i = 0; i < 64; i++) w[i] = '0;
      w[0]  = 16'h1868;  w[1]  = 16'h1098;  w[2]  = 16'h1000;
      w[3]  = 16'h2C00;  w[4]  = 16'h3081;  w[5]  = 16'h307F;
      w[6]  = 16'hC03C;  w[7]  = 16'h012F;  w[8]  = 16'h18E9;
      w[9]  = 16'h30C1;  w[10] = 16'hC001;  w[11] = 16'h26C0;
      w[12] = 16'hC001;  w[13] = 16'h107E;  w[14] = 16'h232F;
      w[15] = 16'hC001;  w[16] = 16'h1087;  w[17] = 16'hE000;
      w[18] = 16'h1089;
      w[24] = 16'h0003;  w[25] = 16'h0007;  w[26] = 16'h0100;
      w[27] = 16'hFFFF;  w[28] = 16'h0020;
      w[40] = 16'h0005;  w[41] = 16'h7FFF;
      for (int i = 0; i < 64; i++) img[i*WORD_W +: WORD_W] = w[i];
      return img;
   endfunction

endpackage

// File: rtl/cpu16_alu.sv
module cpu16_alu
   import cpu16_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y,
   output flags_t            fl
);

   logic [DATA_W:0] sum;

   always_comb begin
      sum = {1'b0, a} + {1'b0, b};
      fl  = '0;
      if (op == ALU_ADD) begin
         y    = sum[DATA_W-1:0];
         fl.c = sum[DATA_W];
         fl.v = (a[DATA_W-1] == b[DATA_W-1]) && (y[DATA_W-1] != a[DATA_W-1]);
      end else begin
         y = a;
      end
      fl.n = y[DATA_W-1];
      fl.z = (y == '0);
   end

endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
   parameter int DATA_W = 16,
   parameter int NREGS  = 4,
   localparam int SEL_W = $clog2(NREGS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [SEL_W-1:0]        wsel,
   input  logic [DATA_W-1:0]       wdata,
   input  logic [SEL_W-1:0]        rsel_a,
   output logic [DATA_W-1:0]       rdata_a,
   input  logic [SEL_W-1:0]        rsel_b,
   output logic [DATA_W-1:0]       rdata_b,
   output logic [NREGS*DATA_W-1:0] dump
);

   logic [NREGS-1:0][DATA_W-1:0] rows;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rows <= '0;
      end else begin
         for (int i = 0; i < NREGS; i++) begin
            if (we && (int'(wsel) == i)) rows[i] <= wdata;
         end
      end
   end

   assign rdata_a = rows[rsel_a];
   assign rdata_b = rows[rsel_b];
   assign dump    = rows;

endmodule

// File: rtl/cpu16_mem.sv
module cpu16_mem #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16,
   localparam int DEPTH = 1 << ADDR_W,
   parameter logic [DEPTH*DATA_W-1:0] IMAGE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [ADDR_W-1:0] dbg_addr,
   output logic [DATA_W-1:0] dbg_data
);

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= IMAGE[i*DATA_W +: DATA_W];
      end else if (we) begin
         cells[addr] <= wdata;
      end
   end

   assign rdata    = cells[addr];
   assign dbg_data = cells[dbg_addr];

endmodule

// File: rtl/cpu16_ctrl.sv
module cpu16_ctrl
   import cpu16_pkg::*;
(
   input  logic [STEP_W-1:0] step,
   input  instr_t            ins,
   input  logic              gt_zero,
   input  logic              stop,
   output ctl_t              ctl
);

   logic              src_mem;
   logic [STEP_W-1:0] ex0;

   always_comb begin
      src_mem = ins.smode[0];
      ex0     = src_mem ? STEP_W'(5) : STEP_W'(3);
      ctl     = '0;
      if (stop) begin
         ctl = '0;
      end else if (step == STEP_W'(0)) begin
         ctl.mar_sel = MAR_PC;
         ctl.pc_inc  = 1'b1;
      end else if (step == STEP_W'(1)) begin
         ctl.mdr_ld = 1'b1;
      end else if (step == STEP_W'(2)) begin
         ctl.ir_ld = 1'b1;
      end else begin
         case (ins.op)
            OP_COPY, OP_ADD: begin
               ctl.alu_op = (ins.op == OP_ADD) ? ALU_ADD : ALU_PASS;
               if (src_mem && step == STEP_W'(3)) begin
                  ctl.mar_sel = ins.smode[1] ? MAR_VAL : MAR_REG;
               end else if (src_mem && step == STEP_W'(4)) begin
                  ctl.mdr_ld = 1'b1;
               end else if (!ins.dmode) begin
                  if (step == ex0) begin
                     ctl.reg_we   = 1'b1;
                     ctl.flag_we  = 1'b1;
                     ctl.step_clr = 1'b1;
                  end
               end else begin
                  if (step == ex0) begin
                     ctl.mar_sel = MAR_VAL;
                     ctl.tmp_ld  = 1'b1;
                  end else if (step == ex0 + STEP_W'(1)) begin
                     ctl.mdr_ld = 1'b1;
                  end else if (step == ex0 + STEP_W'(2)) begin
                     ctl.use_tmp  = 1'b1;
                     ctl.mem_we   = 1'b1;
                     ctl.flag_we  = 1'b1;
                     ctl.step_clr = 1'b1;
                  end
               end
            end
            OP_BPOS: begin
               ctl.pc_br    = gt_zero;
               ctl.step_clr = 1'b1;
            end
            OP_STOP: begin
               ctl.stop_set = 1'b1;
               ctl.step_clr = 1'b1;
            end
            default: ctl.step_clr = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
   import cpu16_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 6,
   parameter int NREGS    = 4,
   parameter bit SEXT_IMM = 1'b1,
   localparam int DEPTH   = 1 << ADDR_W,
   parameter logic [DEPTH*DATA_W-1:0] IMAGE = demo_image()
) (
   input  logic                    clk,
   input  logic                    rst_n,
   output logic                    halted,
   output logic [ADDR_W-1:0]       dbg_pc,
   output logic [WORD_W-1:0]       dbg_ir,
   output logic [3:0]              dbg_flags,
   output logic [NREGS*DATA_W-1:0] dbg_regs,
   input  logic [ADDR_W-1:0]       dbg_addr,
   output logic [DATA_W-1:0]       dbg_data
);

   if (DATA_W != WORD_W) begin : g_bad_width
      $error("DATA_W must equal the instruction word width");
   end
   if (ADDR_W > VAL_W || ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must lie between 2 and the value field width");
   end
   if (NREGS != (1 << RSEL_W)) begin : g_bad_regs
      $error("NREGS must match the register select field");
   end

   logic [ADDR_W-1:0] pc_q, mar_q;
   logic [DATA_W-1:0] mdr_q, tmp_q;
   logic [WORD_W-1:0] ir_q;
   logic [STEP_W-1:0] step_q;
   flags_t            flags_q, alu_fl;
   logic              stop_q;
   instr_t            ins;
   ctl_t              ctl;
   logic [DATA_W-1:0] rd_a, rd_b, imm_ext, opnd, alu_a, alu_b, alu_y, mem_rd;

   assign ins = instr_t'(ir_q);

   if (SEXT_IMM) begin : g_sext
      assign imm_ext = {{(DATA_W-VAL_W){ins.val[VAL_W-1]}}, ins.val};
   end else begin : g_zext
      assign imm_ext = {{(DATA_W-VAL_W){1'b0}}, ins.val};
   end

   always_comb begin
      case (ins.smode)
         2'b00:   opnd = rd_a;
         2'b10:   opnd = imm_ext;
         default: opnd = mdr_q;
      endcase
   end

   assign alu_a = ctl.use_tmp ? tmp_q : opnd;
   assign alu_b = ctl.use_tmp ? mdr_q : rd_b;

   cpu16_ctrl u_ctrl (
      .step    (step_q),
      .ins     (ins),
      .gt_zero (!flags_q.n && !flags_q.z),
      .stop    (stop_q),
      .ctl     (ctl)
   );

   cpu16_alu #(.DATA_W(DATA_W)) u_alu (
      .op (ctl.alu_op),
      .a  (alu_a),
      .b  (alu_b),
      .y  (alu_y),
      .fl (alu_fl)
   );

   cpu16_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (ctl.reg_we),
      .wsel    (ins.dreg),
      .wdata   (alu_y),
      .rsel_a  (ins.sreg),
      .rdata_a (rd_a),
      .rsel_b  (ins.dreg),
      .rdata_b (rd_b),
      .dump    (dbg_regs)
   );

   cpu16_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMAGE(IMAGE)) u_mem (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (ctl.mem_we),
      .addr     (mar_q),
      .wdata    (alu_y),
      .rdata    (mem_rd),
      .dbg_addr (dbg_addr),
      .dbg_data (dbg_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= '0;
         mar_q   <= '0;
         mdr_q   <= '0;
         ir_q    <= '0;
         tmp_q   <= '0;
         flags_q <= '0;
         step_q  <= '0;
         stop_q  <= 1'b0;
      end else begin
         if (ctl.pc_inc) pc_q <= pc_q + ADDR_W'(1);
         // adding the low bits of the value equals a sign-extended add modulo the memory size
         else if (ctl.pc_br) pc_q <= pc_q + ins.val[ADDR_W-1:0];
         case (ctl.mar_sel)
            MAR_PC:  mar_q <= pc_q;
            MAR_REG: mar_q <= rd_a[ADDR_W-1:0];
            MAR_VAL: mar_q <= ins.val[ADDR_W-1:0];
            default: mar_q <= mar_q;
         endcase
         if (ctl.mdr_ld)   mdr_q   <= mem_rd;
         if (ctl.ir_ld)    ir_q    <= mdr_q;
         if (ctl.tmp_ld)   tmp_q   <= opnd;
         if (ctl.flag_we)  flags_q <= alu_fl;
         if (ctl.stop_set) stop_q  <= 1'b1;
         if (!stop_q) step_q <= ctl.step_clr ? '0 : step_q + STEP_W'(1);
      end
   end

   assign halted    = stop_q;
   assign dbg_pc    = pc_q;
   assign dbg_ir    = ir_q;
   assign dbg_flags = flags_q;

endmodule

// File: rtl/cpu16_chk.sv
module cpu16_chk #(
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              halted,
   input logic [ADDR_W-1:0] pc,
   input logic [15:0]       ir,
   input logic [3:0]        flags,
   input logic [2:0]        step,
   input logic              flag_we
);

   a_r8_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && $stable(pc) && $stable(ir) && $stable(flags)));

   a_r2_ir_loads_in_step2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ir) |-> ($past(step) == 3'd2));

   a_r7_pc_moves_on_fetch_or_branch: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pc) |-> ($past(step) == 3'd0 || $past(ir[15:13]) == 3'b110));

   a_r7_branch_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (step == 3'd3 && ir[15:13] == 3'b110) |=> $stable(flags));

   a_r5_copy_clears_vc: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && ir[15:13] == 3'b000) |=> (flags[1:0] == 2'b00));

endmodule

bind cpu16_core cpu16_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .halted  (halted),
   .pc      (dbg_pc),
   .ir      (dbg_ir),
   .flags   (dbg_flags),
   .step    (step_q),
   .flag_we (ctl.flag_we)
);

// File: tb/test_cpu16_core.sv
module test_cpu16_core;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        halted;
   logic [5:0]  dbg_pc;
   logic [15:0] dbg_ir;
   logic [3:0]  dbg_flags;
   logic [63:0] dbg_regs;
   logic [5:0]  dbg_addr;
   logic [15:0] dbg_data;
   int          n_chk = 0;
   int          n_err = 0;

   always #5 clk = ~clk;

   cpu16_core i_cpu16_core (
      .clk(clk), .rst_n(rst_n), .halted(halted), .dbg_pc(dbg_pc),
      .dbg_ir(dbg_ir), .dbg_flags(dbg_flags), .dbg_regs(dbg_regs),
      .dbg_addr(dbg_addr), .dbg_data(dbg_data)
   );

   // {address, expected word} after the program has stopped (R6, R9, R1)
   localparam logic [21:0] MEM_VEC [6] = '{
      {6'h2F, 16'h0127}, {6'h28, 16'h0005}, {6'h29, 16'h7FFF},
      {6'h18, 16'h0003}, {6'h00, 16'h1868}, {6'h11, 16'hE000}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] rg(input int k);
      return dbg_regs[k*16 +: 16];
   endfunction

   task automatic wait_pc(input logic [5:0] v);
      while (dbg_pc !== v) @(negedge clk);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: program did not stop");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      rst_n    = 1'b0;
      dbg_addr = '0;
      repeat (3) @(negedge clk);
      check("R1 pc", dbg_pc, 0);
      check("R1 ir", dbg_ir, 0);
      check("R1 regs", dbg_regs[31:0] | dbg_regs[63:32], 0);
      check("R1 flags", dbg_flags, 0);
      check("R1 halted", halted, 0);
      check("R1 image word 0", dbg_data, 16'h1868);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 pc after first edge", dbg_pc, 1);
      check("R2 ir not yet loaded", dbg_ir, 0);
      repeat (2) @(negedge clk);
      check("R2 ir after third edge", dbg_ir, 16'h1868);
      repeat (3) @(negedge clk);
      check("R3 absolute source into R1", rg(1), 5);
      check("R2 six-cycle op pc", dbg_pc, 1);
      @(negedge clk);
      check("R2 next fetch", dbg_pc, 2);
      repeat (3) @(negedge clk);
      check("R3 immediate into R2", rg(2), 16'h0018);
      @(negedge clk);
      check("R2 four-cycle op", dbg_pc, 3);

      wait_pc(6'd11);
      check("R4 overflow flags", dbg_flags, 4'b1010);
      check("R4 overflow sum", rg(3), 16'h8000);
      wait_pc(6'd13);
      check("R7 not taken on N", rg(3), 16'h0000);
      check("R4 carry zero flags", dbg_flags, 4'b0111);
      wait_pc(6'd15);
      check("R7 not taken on Z", rg(1), 16'hFFFE);
      check("R5 copy flags", dbg_flags, 4'b1000);
      wait_pc(6'd16);
      check("R6 add to memory flags", dbg_flags, 4'b0001);

      while (!halted) @(negedge clk);
      check("R8 pc at stop", dbg_pc, 18);
      check("R7 taken skip", rg(2), 16'h001D);
      check("R3 indirect loop sum", rg(0), 16'h0129);
      repeat (20) @(negedge clk);
      check("R8 halted held", halted, 1);
      check("R8 pc frozen", dbg_pc, 18);
      check("R8 ir frozen", dbg_ir, 16'hE000);
      check("R8 regs frozen", rg(2), 16'h001D);
      check("R8 flags frozen", dbg_flags, 4'b0001);

      for (int i = 0; i < 6; i++) begin
         dbg_addr = MEM_VEC[i][21:16];
         #1;
         check("R9 R6 memory", dbg_data, MEM_VEC[i][15:0]);
      end

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule